// File: doc/BRIEF.md
# Locked IDE Configuration Window

This block sits behind the eight-offset I/O decode of an IDE-style channel and decides, access by access, whether a host access reaches the task-file registers or a hidden set of configuration registers. In its normal, locked state every access is forwarded to the task file unchanged. A fixed three-access handshake, made of ordinary task-file accesses, opens the configuration window. While the window is open, the same offsets reach staged read and write timing registers, a control register, a strap register and a miscellaneous register. A relock write closes the window again.

Two timing sets are held, one for each attached device. Software picks the set it is writing through a device-select bit, places a shared address-setup value in the upper nibble of the miscellaneous register, and then commits everything with a control write. Only the committed values drive the active-timing outputs, so programming in progress never disturbs a running transfer. One host access is one cycle with `bus_valid` high. Read data is combinational.

Top module: `ide_cfg_window`

## Requirements
- R1: After reset the window is locked, `cfg_open` is 0, every active read and write timing byte is 0xFF and `addr_setup` is 0xF.
- R2: While locked, every access asserts `tf_sel` in the same cycle and a read returns `tf_rdata` on `bus_rdata`.
- R3: Two 16-bit reads of offset 1 followed by an 8-bit write of 0x03 to offset 2 open the window, and `cfg_open` is 1 from the cycle after the write. The three handshake accesses are still forwarded to the task file.
- R4: Any access that is not the next step aborts a partial handshake, and cycles with no access do not abort it. A 16-bit read of offset 1 that arrives out of turn counts as a new first step.
- R5: While open, `tf_sel` stays 0. A read returns the selected configuration byte zero-extended to 16 bits, and offsets 2, 4 and 7 read as zero.
- R6: While open, offset 0 holds the staged read timing and offset 1 holds the staged write timing of the device that miscellaneous bit 0 selects. The miscellaneous register sits at offset 6 and reads back as written.
- R7: Writing 0x85 to offset 3 (control) while open copies both staged timing sets to the active outputs. Set 0 goes to bits 7:0 and set 1 goes to bits 15:8. Any other control value is stored and read back but commits nothing.
- R8: Active timing outputs and `addr_setup` change only on a committing control write.
- R9: Strap register (offset 5) bit 0 reads the `strap_clk25` pin, where 0 means a 33 MHz bus clock and 1 means 25 MHz. Bits 7:1 are writable.
- R10: While open, an 8-bit write of 0x83 to offset 2 relocks the window, and `cfg_open` is 0 from the next cycle. Any other write to offset 2 leaves the window open.
- R11: The commit loads `addr_setup` from miscellaneous bits 7:4. This single value is shared by both devices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | One host access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| bus_offset | input | 3 | Port offset within the channel |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| tf_sel | output | 1 | Access is forwarded to the task file |
| tf_rdata | input | 16 | Task-file read data |
| strap_clk25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| cfg_open | output | 1 | Configuration window is open |
| act_rd_timing | output | 16 | Committed read timing, device 1 in the upper byte |
| act_wr_timing | output | 16 | Committed write timing, device 1 in the upper byte |
| addr_setup | output | 4 | Committed shared address-setup value |

## Verification
On every cycle the assertions check the routing and hold properties. No access reaches the task file while the window is open, and every locked access does. The window opens only right after the unlock write, and a relock write always closes it. The active timings and address setup stay still unless a commit write occurs. Other behaviour needs the bench's scripted scenarios. These cover the abort and restart paths of the handshake, per-device staging selected by the miscellaneous bit, the split between committing and non-committing control values, and the strap pin readback.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2,
        SEQ_OPEN = 2'd3
    } seq_state_e;

    localparam logic [2:0] OFF_PROBE  = 3'd1;
    localparam logic [2:0] OFF_KEY    = 3'd2;
    localparam logic [2:0] OFF_RDTIM  = 3'd0;
    localparam logic [2:0] OFF_WRTIM  = 3'd1;
    localparam logic [2:0] OFF_CTRL   = 3'd3;
    localparam logic [2:0] OFF_STRAP  = 3'd5;
    localparam logic [2:0] OFF_MISC   = 3'd6;

    localparam logic [7:0] KEY_UNLOCK = 8'h03;
    localparam logic [7:0] KEY_RELOCK = 8'h83;
    localparam logic [7:0] KEY_COMMIT = 8'h85;
endpackage

// File: rtl/ide_unlock_seq.sv
module ide_unlock_seq
    import ide_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_wide,
    input  logic [2:0] acc_offset,
    input  logic [7:0] acc_byte,
    output logic       win_open
);
    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic      probe_hit, key_hit, relock_hit;

    always_comb begin
        probe_hit  = acc_valid && !acc_write && acc_wide && (acc_offset == OFF_PROBE);
        key_hit    = acc_valid && acc_write && !acc_wide && (acc_offset == OFF_KEY)
                     && (acc_byte == KEY_UNLOCK);
        relock_hit = acc_valid && acc_write && !acc_wide && (acc_offset == OFF_KEY)
                     && (acc_byte == KEY_RELOCK);
        s_d = s_q;
        case (s_q.st)
            SEQ_IDLE: if (probe_hit) s_d.st = SEQ_ONE;
            SEQ_ONE: begin
                if (probe_hit)      s_d.st = SEQ_TWO;
                else if (acc_valid) s_d.st = SEQ_IDLE;
            end
            SEQ_TWO: begin
                if (key_hit)        s_d.st = SEQ_OPEN;
                else if (probe_hit) s_d.st = SEQ_ONE;
                else if (acc_valid) s_d.st = SEQ_IDLE;
            end
            SEQ_OPEN: if (relock_hit) s_d.st = SEQ_IDLE;
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE};
        else        s_q <= s_d;
    end

    assign win_open = (s_q.st == SEQ_OPEN);
endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
    import ide_cfg_pkg::*;
#(
    parameter int DEVS   = 2,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 4,
    localparam int SEL_W = (DEVS > 1) ? $clog2(DEVS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              offset,
    input  logic [REG_W-1:0]        wdata,
    input  logic                    strap_pin,
    output logic [REG_W-1:0]        rdata,
    output logic [DEVS*REG_W-1:0]   act_rd,
    output logic [DEVS*REG_W-1:0]   act_wr,
    output logic [ADDR_W-1:0]       act_addr
);
    localparam logic [REG_W-1:0] SLOWEST = '1;

    typedef struct packed {
        logic [DEVS-1:0][REG_W-1:0] stg_rd;
        logic [DEVS-1:0][REG_W-1:0] stg_wr;
        logic [DEVS-1:0][REG_W-1:0] live_rd;
        logic [DEVS-1:0][REG_W-1:0] live_wr;
        logic [REG_W-1:0]           ctrl;
        logic [REG_W-1:0]           strap_hi;
        logic [REG_W-1:0]           misc;
        logic [ADDR_W-1:0]          live_addr;
    } cfg_regs_t;

    cfg_regs_t r_d, r_q;
    logic [SEL_W-1:0] dev_sel;

    assign dev_sel = r_q.misc[SEL_W-1:0];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (offset)
                OFF_RDTIM: r_d.stg_rd[dev_sel] = wdata;
                OFF_WRTIM: r_d.stg_wr[dev_sel] = wdata;
                OFF_CTRL: begin
                    r_d.ctrl = wdata;
                    if (wdata == KEY_COMMIT) begin
                        r_d.live_rd   = r_q.stg_rd;
                        r_d.live_wr   = r_q.stg_wr;
                        r_d.live_addr = r_q.misc[REG_W-1 -: ADDR_W];
                    end
                end
                OFF_STRAP: r_d.strap_hi = {wdata[REG_W-1:1], 1'b0};
                OFF_MISC:  r_d.misc = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (offset)
            OFF_RDTIM: rdata = r_q.stg_rd[dev_sel];
            OFF_WRTIM: rdata = r_q.stg_wr[dev_sel];
            OFF_CTRL:  rdata = r_q.ctrl;
            OFF_STRAP: rdata = {r_q.strap_hi[REG_W-1:1], strap_pin};
            OFF_MISC:  rdata = r_q.misc;
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.stg_rd    <= {DEVS{SLOWEST}};
            r_q.stg_wr    <= {DEVS{SLOWEST}};
            r_q.live_rd   <= {DEVS{SLOWEST}};
            r_q.live_wr   <= {DEVS{SLOWEST}};
            r_q.live_addr <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEVS; g++) begin : g_dev
            assign act_rd[g*REG_W +: REG_W] = r_q.live_rd[g];
            assign act_wr[g*REG_W +: REG_W] = r_q.live_wr[g];
        end
    endgenerate

    assign act_addr = r_q.live_addr;
endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window
    import ide_cfg_pkg::*;
#(
    parameter int DEVS   = 2,
    parameter int REG_W  = 8,
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic                  bus_wide,
    input  logic [2:0]            bus_offset,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  tf_sel,
    input  logic [BUS_W-1:0]      tf_rdata,
    input  logic                  strap_clk25,
    output logic                  cfg_open,
    output logic [DEVS*REG_W-1:0] act_rd_timing,
    output logic [DEVS*REG_W-1:0] act_wr_timing,
    output logic [ADDR_W-1:0]     addr_setup
);
    logic             win_open;
    logic [REG_W-1:0] cfg_rdata;
    logic             cfg_wr_en;

    ide_unlock_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (bus_valid),
        .acc_write  (bus_write),
        .acc_wide   (bus_wide),
        .acc_offset (bus_offset),
        .acc_byte   (bus_wdata[7:0]),
        .win_open   (win_open)
    );

    assign cfg_wr_en = bus_valid && bus_write && win_open;

    ide_cfg_regs #(
        .DEVS   (DEVS),
        .REG_W  (REG_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .offset    (bus_offset),
        .wdata     (bus_wdata[REG_W-1:0]),
        .strap_pin (strap_clk25),
        .rdata     (cfg_rdata),
        .act_rd    (act_rd_timing),
        .act_wr    (act_wr_timing),
        .act_addr  (addr_setup)
    );

    assign tf_sel    = bus_valid && !win_open;
    assign bus_rdata = win_open ? {{(BUS_W-REG_W){1'b0}}, cfg_rdata} : tf_rdata;
    assign cfg_open  = win_open;
endmodule

// File: rtl/ide_cfg_window_chk.sv
module ide_cfg_window_chk #(
    parameter int DEVS   = 2,
    parameter int REG_W  = 8,
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_valid,
    input logic                  bus_write,
    input logic                  bus_wide,
    input logic [2:0]            bus_offset,
    input logic [BUS_W-1:0]      bus_wdata,
    input logic                  tf_sel,
    input logic                  cfg_open,
    input logic [DEVS*REG_W-1:0] act_rd_timing,
    input logic [DEVS*REG_W-1:0] act_wr_timing,
    input logic [ADDR_W-1:0]     addr_setup
);
    logic commit_wr, key_wr, relock_wr;
    assign commit_wr = cfg_open && bus_valid && bus_write && bus_offset == 3'd3
                       && bus_wdata[7:0] == 8'h85;
    assign key_wr    = bus_valid && bus_write && !bus_wide && bus_offset == 3'd2
                       && bus_wdata[7:0] == 8'h03;
    assign relock_wr = cfg_open && bus_valid && bus_write && !bus_wide
                       && bus_offset == 3'd2 && bus_wdata[7:0] == 8'h83;

    a_r2_locked_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_valid) |-> tf_sel);

    a_r5_open_isolates: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open |-> !tf_sel);

    a_r3_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && !key_wr) |=> !cfg_open);

    a_r10_relock_closes: assert property (@(posedge clk) disable iff (!rst_n)
        relock_wr |=> !cfg_open);

    a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_wr |=> ($stable(act_rd_timing) && $stable(act_wr_timing)
                        && $stable(addr_setup)));
endmodule

bind ide_cfg_window ide_cfg_window_chk #(
    .DEVS   (DEVS),
    .REG_W  (REG_W),
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/ide_cfg_window_tb.sv
module ide_cfg_window_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_wide = 1'b0;
    logic [2:0]  bus_offset = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tf_sel;
    logic [15:0] tf_rdata = 16'hA5C3;
    logic        strap_clk25 = 1'b1;
    logic        cfg_open;
    logic [15:0] act_rd_timing, act_wr_timing;
    logic [3:0]  addr_setup;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        chk_rd;
        logic [15:0] rd;
        logic        tf;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    ide_cfg_window u_dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares each access against the queued expectation
    always @(negedge clk) begin
        if (bus_valid && rst_n) begin
            if (sb.size() == 0) begin
                chk("scoreboard", 0, 1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, {31'd0, tf_sel}, {31'd0, e.tf});
                if (e.chk_rd) chk(e.req, {16'd0, bus_rdata}, {16'd0, e.rd});
            end
        end
    end

    task automatic acc(input logic w, input logic wide, input logic [2:0] off,
                       input logic [15:0] d, input logic crd, input logic [15:0] erd,
                       input logic etf, input string req);
        exp_t e;
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = w; bus_wide = wide; bus_offset = off; bus_wdata = d;
        e.chk_rd = crd; e.rd = erd; e.tf = etf; e.req = req;
        sb.push_back(e);
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic cwr(input logic [2:0] off, input logic [7:0] d, input string req);
        acc(1'b1, 1'b0, off, {8'h00, d}, 1'b0, 16'h0, 1'b0, req);
    endtask

    task automatic crd(input logic [2:0] off, input logic [15:0] exp, input string req);
        acc(1'b0, 1'b0, off, 16'h0, 1'b1, exp, 1'b0, req);
    endtask

    task automatic probe(input string req);
        acc(1'b0, 1'b1, 3'd1, 16'h0, 1'b1, 16'hA5C3, 1'b1, req);
    endtask

    task automatic key(input string req);
        acc(1'b1, 1'b0, 3'd2, 16'h0003, 1'b0, 16'h0, 1'b1, req);
    endtask

    task automatic see(input string req, logic [31:0] act, logic [31:0] exp);
        @(negedge clk);
        chk(req, act, exp);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        see("R1 open", {31'd0, cfg_open}, 0);
        chk("R1 rd", {16'd0, act_rd_timing}, 32'hFFFF);
        chk("R1 wr", {16'd0, act_wr_timing}, 32'hFFFF);
        chk("R1 addr", {28'd0, addr_setup}, 32'hF);
        // R2 locked pass-through
        acc(1'b0, 1'b0, 3'd3, 16'h0, 1'b1, 16'hA5C3, 1'b1, "R2 read");
        acc(1'b1, 1'b1, 3'd0, 16'h1234, 1'b0, 16'h0, 1'b1, "R2 write");
        // R4 byte read aborts
        probe("R4 p1"); acc(1'b0, 1'b0, 3'd1, 16'h0, 1'b1, 16'hA5C3, 1'b1, "R4 byte");
        probe("R4 p2"); key("R4 k1");
        see("R4 abort stays closed", {31'd0, cfg_open}, 0);
        // R4 extra read, then key: closed
        probe("R4 a"); probe("R4 b"); probe("R4 c"); key("R4 k2");
        see("R4 third read closed", {31'd0, cfg_open}, 0);
        // R4 restart counts: four reads then key opens; idle cycles do not abort
        probe("R4 d"); probe("R4 e"); probe("R4 f");
        repeat (3) @(posedge clk);
        probe("R4 g"); key("R4 k3");
        see("R4 restart opens", {31'd0, cfg_open}, 1);
        // R3 clean open after relock
        cwr(3'd2, 8'h83, "R10 relock");
        see("R10 closed", {31'd0, cfg_open}, 0);
        probe("R3 p1"); probe("R3 p2"); key("R3 key");
        see("R3 open", {31'd0, cfg_open}, 1);
        // R5 routing while open
        crd(3'd6, 16'h0000, "R5 misc reset");
        crd(3'd4, 16'h0000, "R5 unmapped");
        crd(3'd0, 16'h00FF, "R5 staged reset");
        // R6 staging per device
        cwr(3'd6, 8'h20, "R6 sel0");
        cwr(3'd0, 8'h59, "R6 rd0"); cwr(3'd1, 8'h46, "R6 wr0");
        cwr(3'd6, 8'h31, "R6 sel1");
        cwr(3'd0, 8'h30, "R6 rd1"); cwr(3'd1, 8'h20, "R6 wr1");
        crd(3'd0, 16'h0030, "R6 rd1 back");
        crd(3'd6, 16'h0031, "R6 misc back");
        see("R8 no early update", {16'd0, act_rd_timing}, 32'hFFFF);
        cwr(3'd6, 8'h20, "R6 sel0 again");
        crd(3'd0, 16'h0059, "R6 rd0 back");
        crd(3'd1, 16'h0046, "R6 wr0 back");
        // R7 non-commit value
        cwr(3'd3, 8'h84, "R7 ctrl 84");
        see("R7 no commit", {16'd0, act_rd_timing}, 32'hFFFF);
        crd(3'd3, 16'h0084, "R7 ctrl back");
        // R7 / R11 commit
        cwr(3'd3, 8'h85, "R7 commit");
        see("R7 rd", {16'd0, act_rd_timing}, 32'h3059);
        chk("R7 wr", {16'd0, act_wr_timing}, 32'h2046);
        chk("R11 addr", {28'd0, addr_setup}, 32'h2);
        // R8 later staging leaves active alone
        cwr(3'd0, 8'h11, "R8 restage");
        cwr(3'd6, 8'h70, "R8 misc");
        see("R8 rd hold", {16'd0, act_rd_timing}, 32'h3059);
        chk("R8 addr hold", {28'd0, addr_setup}, 32'h2);
        // R9 strap
        crd(3'd5, 16'h0001, "R9 pin 25MHz");
        strap_clk25 = 1'b0;
        crd(3'd5, 16'h0000, "R9 pin 33MHz");
        cwr(3'd5, 8'hFF, "R9 strap write");
        crd(3'd5, 16'h00FE, "R9 strap hi");
        // R10 other offset-2 write keeps window
        cwr(3'd2, 8'h55, "R10 other");
        see("R10 still open", {31'd0, cfg_open}, 1);
        cwr(3'd2, 8'h83, "R10 relock2");
        see("R10 closed2", {31'd0, cfg_open}, 0);
        acc(1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 16'hA5C3, 1'b1, "R2 after relock");
        see("R8 after relock", {16'd0, act_rd_timing}, 32'h3059);
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule